// File: doc/BRIEF.md
# Three-Phase Half-Bridge Shoot-Through Guard

This block sits between a PWM source and the gate drivers of a three-phase inverter bridge. Each phase has two command inputs, one for the upper switch and one for the lower switch. Both are active low: a low level asks for the switch to conduct. Each command is synchronised to the block clock and passed on to an active-high gate-enable output. When both commands of one phase ask for conduction at the same time, the block turns off both gates of that phase and sets a latched fault flag for that phase.

One shared active-low fault output shows the latched state of all phases. It is driven low while any phase is latched and sits high otherwise, the same levels an open-drain pin with a pull-up would show. A latched phase keeps both of its gates off. It clears only after each of its two commands has gone from high to low at least once after the fault was set; the second of these two edges clears it. If both commands of the phase are low together again before that, the phase trips again and starts from scratch. The other phases keep working normally while one phase is latched.

Top module: `shoot_guard`

## Requirements
- R1: With no phase latched, a phase whose upper command is low (0) and lower command is high (1) drives gate_hi=1 and gate_lo=0 for that phase; the mirror case drives gate_lo=1 and gate_hi=0; both commands high drives both gates 0.
- R2: When a phase's synchronised upper and lower commands are both low, both gates of that phase are 0 in that same cycle.
- R3: One clock after a phase's synchronised commands are both low, that phase is latched and fault_n is 0.
- R4: While a phase is latched, both of its gates stay 0 whatever its commands are, and fault_n stays 0 after both commands return high.
- R5: A latched phase clears on the later of one falling edge of its upper command and one falling edge of its lower command, both taken after the trip. A single falling edge does not clear it. After the clear, that phase's gates follow R1 again, and fault_n returns to 1 if no other phase is latched.
- R6: While one phase is latched, the other phases keep driving their gates as R1 describes.
- R7: While rst_n is 0, all gates are 0 and fault_n is 1. A latch that was set before the reset does not come back after reset is released.
- R8: A change on a command input reaches the gate outputs after exactly SYNC_STAGES rising clock edges (2 by default), not earlier.
- R9: If both commands of a latched phase are low together again before it clears, any falling edge already seen since the trip is forgotten, and the clear needs a new falling edge on each command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_cmd_n | input | NPHASE | Upper-switch commands, bit p for phase p, active low |
| lo_cmd_n | input | NPHASE | Lower-switch commands, bit p for phase p, active low |
| gate_hi | output | NPHASE | Upper-switch gate enables, active high |
| gate_lo | output | NPHASE | Lower-switch gate enables, active high |
| fault_n | output | 1 | Shared latched fault, 0 while any phase is latched |

## Verification
A table of legal command mixes, with each phase upper-only, lower-only or idle in different combinations, checks that pass-through never mixes up phases or arms. A trip on one phase while another phase drives its upper gate separates per-phase gating from a global shutdown. The clearing sequences feed a single falling edge, a return to idle, and a repeated both-low that re-arms the latch. These show whether the clear really waits for the later of two fresh edges. A drive-and-sample step one edge apart pins the synchroniser depth, and a reset during a fault shows the latch does not survive reset.

// File: rtl/shoot_pkg.sv
package shoot_pkg;
   // Idle level of an active-low command: switch off.
   localparam logic CMD_IDLE = 1'b1;
   // Minimum synchroniser depth accepted by the block.
   localparam int MIN_SYNC = 2;
endpackage

// File: rtl/cmd_sync.sv
module cmd_sync
   import shoot_pkg::*;
#(
   parameter int WIDTH  = 6,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);
   generate
      if (STAGES < MIN_SYNC) begin : g_bad_depth
         $error("cmd_sync: STAGES must be at least MIN_SYNC");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage_q[s] <= {WIDTH{CMD_IDLE}};
            end else if (s == 0) begin
               stage_q[s] <= d_in;
            end else begin
               stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
         end
      end
   endgenerate

   assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/fall_detect.sv
module fall_detect
   import shoot_pkg::*;
#(
   parameter int WIDTH = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level,
   output logic [WIDTH-1:0] fell
);
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= {WIDTH{CMD_IDLE}};
      else        prev_q <= level;
   end

   assign fell = prev_q & ~level;
endmodule

// File: rtl/phase_guard.sv
module phase_guard (
   input  logic clk,
   input  logic rst_n,
   input  logic hi_s_n,
   input  logic lo_s_n,
   input  logic hi_fell,
   input  logic lo_fell,
   output logic gate_hi,
   output logic gate_lo,
   output logic latched
);
   logic both_on;
   logic fault_q, seen_hi_q, seen_lo_q;
   logic hi_done, lo_done;

   assign both_on = ~hi_s_n & ~lo_s_n;
   assign hi_done = hi_fell | seen_hi_q;
   assign lo_done = lo_fell | seen_lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_q   <= 1'b0;
         seen_hi_q <= 1'b0;
         seen_lo_q <= 1'b0;
      end else if (both_on) begin
         fault_q   <= 1'b1;
         seen_hi_q <= 1'b0;
         seen_lo_q <= 1'b0;
      end else if (fault_q) begin
         if (hi_done && lo_done) begin
            fault_q   <= 1'b0;
            seen_hi_q <= 1'b0;
            seen_lo_q <= 1'b0;
         end else begin
            seen_hi_q <= hi_done;
            seen_lo_q <= lo_done;
         end
      end else begin
         seen_hi_q <= 1'b0;
         seen_lo_q <= 1'b0;
      end
   end

   assign gate_hi = ~hi_s_n &  lo_s_n & ~fault_q;
   assign gate_lo =  hi_s_n & ~lo_s_n & ~fault_q;
   assign latched = fault_q;

   // R3
   latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      both_on |=> fault_q);
   // R4
   gates_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_q |-> (!gate_hi && !gate_lo));
   // R5
   clear_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fault_q) |-> $past(hi_fell || lo_fell));
   // R9
   rearm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_q && both_on) |=> (fault_q && !seen_hi_q && !seen_lo_q));
endmodule

// File: rtl/shoot_guard.sv
module shoot_guard
   import shoot_pkg::*;
#(
   parameter int NPHASE      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPHASE-1:0] up_cmd_n,
   input  logic [NPHASE-1:0] lo_cmd_n,
   output logic [NPHASE-1:0] gate_hi,
   output logic [NPHASE-1:0] gate_lo,
   output logic              fault_n
);
   localparam int NCMD = 2 * NPHASE;

   generate
      if (NPHASE < 1) begin : g_bad_phase
         $error("shoot_guard: NPHASE must be at least 1");
      end
   endgenerate

   logic [NCMD-1:0]   raw_cmd, sync_cmd, fell_cmd;
   logic [NPHASE-1:0] hi_s_n, lo_s_n, hi_fell, lo_fell, latched;

   assign raw_cmd = {lo_cmd_n, up_cmd_n};

   cmd_sync #(.WIDTH(NCMD), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (raw_cmd),
      .d_out (sync_cmd)
   );

   fall_detect #(.WIDTH(NCMD)) u_fall (
      .clk   (clk),
      .rst_n (rst_n),
      .level (sync_cmd),
      .fell  (fell_cmd)
   );

   assign hi_s_n  = sync_cmd[NPHASE-1:0];
   assign lo_s_n  = sync_cmd[NCMD-1:NPHASE];
   assign hi_fell = fell_cmd[NPHASE-1:0];
   assign lo_fell = fell_cmd[NCMD-1:NPHASE];

   generate
      for (genvar p = 0; p < NPHASE; p++) begin : g_phase
         phase_guard u_guard (
            .clk     (clk),
            .rst_n   (rst_n),
            .hi_s_n  (hi_s_n[p]),
            .lo_s_n  (lo_s_n[p]),
            .hi_fell (hi_fell[p]),
            .lo_fell (lo_fell[p]),
            .gate_hi (gate_hi[p]),
            .gate_lo (gate_lo[p]),
            .latched (latched[p])
         );
      end
   endgenerate

   assign fault_n = ~|latched;

   // R3
   trip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fault_n) |-> $past(|(~hi_s_n & ~lo_s_n)));
   // R2
   arm_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((gate_hi & gate_lo) == '0));
endmodule

// File: tb/tb_shoot_guard.sv
module tb_shoot_guard;
   localparam int NP = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] up_cmd_n = '1;
   logic [NP-1:0] lo_cmd_n = '1;
   logic [NP-1:0] gate_hi, gate_lo;
   logic          fault_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   shoot_guard #(.NPHASE(NP), .SYNC_STAGES(2)) dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .up_cmd_n (up_cmd_n),
      .lo_cmd_n (lo_cmd_n),
      .gate_hi  (gate_hi),
      .gate_lo  (gate_lo),
      .fault_n  (fault_n)
   );

   // vector: up_n[12:10] lo_n[9:7] exp_hi[6:4] exp_lo[3:1] exp_fault_n[0]
   localparam int NV = 5;
   localparam logic [12:0] VEC [NV] = '{
      {3'b110, 3'b111, 3'b001, 3'b000, 1'b1},
      {3'b111, 3'b010, 3'b000, 3'b101, 1'b1},
      {3'b011, 3'b110, 3'b100, 3'b001, 1'b1},
      {3'b101, 3'b010, 3'b010, 3'b101, 1'b1},
      {3'b111, 3'b111, 3'b000, 3'b000, 1'b1}
   };

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [NP-1:0] up, input logic [NP-1:0] lo);
      @(negedge clk);
      up_cmd_n = up;
      lo_cmd_n = lo;
      repeat (4) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      // R7: reset state, with commands asking for conduction
      up_cmd_n = 3'b110;
      repeat (3) @(negedge clk);
      check("R7 gates in reset", {2'b0, gate_hi, gate_lo}, 8'h00);
      check("R7 fault_n in reset", {7'b0, fault_n}, 8'h01);
      up_cmd_n = '1;
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1: pass-through table
      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][12:10], VEC[i][9:7]);
         check("R1 gate_hi", {5'b0, gate_hi}, {5'b0, VEC[i][6:4]});
         check("R1 gate_lo", {5'b0, gate_lo}, {5'b0, VEC[i][3:1]});
         check("R1 fault_n", {7'b0, fault_n}, {7'b0, VEC[i][0]});
      end

      // R8: latency of exactly two edges
      @(negedge clk);
      up_cmd_n = 3'b101;
      @(negedge clk);
      check("R8 one edge no change", {5'b0, gate_hi}, 8'h00);
      @(negedge clk);
      check("R8 two edges change", {5'b0, gate_hi}, 8'h02);

      // R2: gates off in the cycle the synced pair is both low
      @(negedge clk);
      up_cmd_n = 3'b111;
      lo_cmd_n = 3'b111;
      repeat (3) @(negedge clk);
      up_cmd_n = 3'b110;
      lo_cmd_n = 3'b110;
      @(negedge clk);
      @(negedge clk);
      check("R2 both off immediately", {6'b0, gate_hi[0], gate_lo[0]}, 8'h00);
      // R3: latched one edge later
      @(negedge clk);
      check("R3 fault_n low", {7'b0, fault_n}, 8'h00);
      // R6: phase 2 upper requested while phase 0 latched
      up_cmd_n = 3'b010;
      repeat (4) @(negedge clk);
      check("R6 phase2 passes", {5'b0, gate_hi}, 8'h04);
      // R4: commands back high, still latched
      drive(3'b111, 3'b111);
      check("R4 still latched", {7'b0, fault_n}, 8'h00);
      // R5: single falling edge (upper) does not clear; R4 gate stays off
      drive(3'b110, 3'b111);
      check("R5 single edge holds", {7'b0, fault_n}, 8'h00);
      check("R4 gate held off", {5'b0, gate_hi}, 8'h00);
      drive(3'b111, 3'b111);
      // R5: later lower edge clears, gate follows
      drive(3'b111, 3'b110);
      check("R5 cleared", {7'b0, fault_n}, 8'h01);
      check("R5 gate_lo resumes", {5'b0, gate_lo}, 8'h01);
      drive(3'b111, 3'b111);

      // R9: re-arm on phase 1
      drive(3'b101, 3'b101);
      check("R9 trip", {7'b0, fault_n}, 8'h00);
      drive(3'b111, 3'b111);
      drive(3'b101, 3'b111);   // upper edge seen
      drive(3'b101, 3'b101);   // both low again: re-arm
      drive(3'b111, 3'b111);
      drive(3'b111, 3'b101);   // lower edge only after re-arm
      check("R9 one new edge holds", {7'b0, fault_n}, 8'h00);
      drive(3'b101, 3'b111);   // upper edge completes clear
      check("R9 cleared", {7'b0, fault_n}, 8'h01);
      check("R9 gate_hi resumes", {5'b0, gate_hi}, 8'h02);
      drive(3'b111, 3'b111);

      // R7: reset during a fault
      drive(3'b011, 3'b011);
      check("R7 pre-reset trip", {7'b0, fault_n}, 8'h00);
      @(negedge clk);
      up_cmd_n = '1;
      lo_cmd_n = '1;
      rst_n = 1'b0;
      @(negedge clk);
      check("R7 reset clears", {7'b0, fault_n}, 8'h01);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R7 no latch after reset", {7'b0, fault_n}, 8'h01);

      finish_run();
   end
endmodule